// File: doc/BRIEF.md
# Endian-Aware Bus Sizing Unit

This block sits between a 32-bit internal master and an external data bus that can be 8, 16 or 32 bits wide. The master issues one access at a time, giving an address, an operand size (byte, word or longword), a direction and write data. The unit places the operand bytes on the right data lanes and drives a strobe for every lane that carries valid data. When the operand is wider than the device, the unit breaks the access into several narrower bus cycles and puts the read bytes back together into one 32-bit result.

Byte order is fixed once per reset. A mode input is captured on the first clock after reset is released. Low selects big endian, where the lowest address holds the most significant byte. High selects little endian, where the lowest address holds the least significant byte. Memory timing and wait states are out of scope. Every bus cycle completes in a single clock, and the device returns read data in that same cycle.

Top module: `bus_sizer`

## Requirements
- R1: `endian_mode_i` is captured on the first rising clock edge after `rst_ni` goes high. The value 0 selects big endian and 1 selects little endian. The captured value holds until the next reset, whatever the input does afterwards. `ready_o` stays low until that capture has happened. During reset, `bus_cyc_o`, `done_o` and `err_o` are all low.
- R2: `size_i` and `dev_width_i` use the same code: 0 = byte, 1 = word, 2 = longword. Code 3 is reserved.
- R3: On a 32-bit device in big endian, a byte access at address offset k (0..3) drives operand bits 7:0 on lane 3-k. Lane n means data bits 8n+7:8n. Only strobe bit 3-k is set, and the bus address is the address with bits 1:0 cleared.
- R4: On a 32-bit device in big endian, a word at offset 0 uses bits 31:16 with strobes 3 and 2. A word at offset 2 uses bits 15:0 with strobes 1 and 0. In both cases operand bits 15:8 go on the higher lane. A longword drives the operand unchanged with all four strobes set.
- R5: In little endian the lane choice is mirrored: a byte at offset k uses lane k and strobe bit k. Operand byte 0 sits on the lowest lane of the access.
- R6: A byte-wide device uses only lane 0 and strobe bit 0. A word-wide device uses only lanes 1:0. The lower-addressed byte of a device word goes on lane 1 in big endian and on lane 0 in little endian.
- R7: An operand wider than the device is carried in (operand bytes / device bytes) bus cycles on consecutive clocks. The first cycle is at the operand address, and each later cycle adds the device width in bytes.
- R8: Read data is taken from `bus_rdata_i` during each bus cycle and placed by byte order. It is presented on `rdata_o` while `done_o` is high. Bits above the operand size are zero.
- R9: A request is rejected if it is a word at an odd address, a longword at an address that is not a multiple of 4, or carries a reserved size or width code. A rejected request raises `err_o` for one clock, starts no bus cycle and produces no `done_o`.
- R10: `ready_o` is high only while the unit is idle and configured. A request is taken on a rising edge where `req_i` and `ready_o` are both high, and the master holds the request stable until `done_o` or `err_o`. The bus cycles start on the next clock. `done_o` is a one-clock pulse on the clock after the last bus cycle.
- R11: Each bus cycle sets exactly min(operand bytes, device bytes) strobes. `bus_strb_o` is zero outside bus cycles. `bus_wdata_o` is zero except on the active lanes of write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| endian_mode_i | input | 1 | Byte order select, captured after reset (0 big, 1 little) |
| dev_width_i | input | 2 | Device bus width code |
| req_i | input | 1 | Access request |
| ready_o | output | 1 | Unit idle and able to take a request |
| addr_i | input | ADDR_W | Byte address of the operand |
| size_i | input | 2 | Operand size code |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write operand, right aligned |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | One-clock rejection pulse |
| rdata_o | output | 32 | Read operand, right aligned, zero extended |
| bus_cyc_o | output | 1 | External bus cycle active |
| bus_we_o | output | 1 | Bus cycle direction |
| bus_addr_o | output | ADDR_W | Bus cycle address |
| bus_strb_o | output | 4 | Per-lane byte strobes |
| bus_wdata_o | output | 32 | Lane-steered write data |
| bus_rdata_i | input | 32 | Read data from the device, sampled during a bus cycle |

## Verification
Some properties are checked by assertions on every clock. These cover the strobe count per bus cycle, the confinement of strobes to the device's lanes, the address step between split cycles, the hold of the captured byte order, the rule that a rejection starts no bus cycle, and the single-clock done pulse that follows a bus cycle. Other behaviour depends on the operand's values, so only the directed scenarios can show it. That covers which lane each operand byte reaches in each byte order, the exact data on the lanes, and the reassembled read value.

// File: rtl/bus_sizer_pkg.sv
`timescale 1ns/1ps
package bus_sizer_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SZ_RSVD = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} state_e;
endpackage

// File: rtl/bus_sizer_ctrl.sv
`timescale 1ns/1ps
module bus_sizer_ctrl
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              endian_mode_i,
  input  logic [1:0]        dev_width_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_cyc_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              le_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        dw_o,
  output logic [1:0]        sz_o,
  output logic [1:0]        op_off_o,
  output logic [1:0]        win_off_o,
  output logic              clr_o
);
  logic              cfg_q, le_q, we_q, err_q;
  state_e            st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sz_q, dw_q, cnt_q, last_cnt, step, wmask;
  logic [DATA_W-1:0] wd_q;
  logic              accept, bad_req, split;

  assign bad_req = (size_i == SZ_RSVD) || (dev_width_i == SZ_RSVD) ||
                   (size_i == SZ_WORD && addr_i[0]) ||
                   (size_i == SZ_LONG && addr_i[1:0] != 2'd0);
  assign accept  = (st_q == ST_IDLE) && cfg_q && req_i;

  assign split    = sz_q > dw_q;
  assign last_cnt = split ? 2'((3'd1 << (sz_q - dw_q)) - 3'd1) : 2'd0;
  assign step     = cnt_q << dw_q;
  assign wmask    = 2'((3'd1 << dw_q) - 3'd1);
  // window offset of current device cycle inside the aligned 4-byte group
  assign win_off_o = split ? (addr_q[1:0] + step) : (addr_q[1:0] & ~wmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= 1'b0;
      le_q   <= 1'b0;
      st_q   <= ST_IDLE;
      addr_q <= '0;
      sz_q   <= SZ_BYTE;
      dw_q   <= SZ_BYTE;
      we_q   <= 1'b0;
      wd_q   <= '0;
      err_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      if (!cfg_q) begin
        cfg_q <= 1'b1;
        le_q  <= endian_mode_i;
      end
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q <= addr_i;
          sz_q   <= size_i;
          dw_q   <= dev_width_i;
          we_q   <= we_i;
          wd_q   <= wdata_i;
          err_q  <= bad_req;
          cnt_q  <= 2'd0;
          st_q   <= bad_req ? ST_RESP : ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == last_cnt) st_q <= ST_RESP;
          else                   cnt_q <= cnt_q + 2'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == ST_IDLE) && cfg_q;
  assign bus_cyc_o  = (st_q == ST_RUN);
  assign done_o     = (st_q == ST_RESP) && !err_q;
  assign err_o      = (st_q == ST_RESP) && err_q;
  assign bus_addr_o = {addr_q[ADDR_W-1:2], win_off_o};
  assign le_o       = le_q;
  assign we_o       = we_q;
  assign wdata_o    = wd_q;
  assign dw_o       = dw_q;
  assign sz_o       = sz_q;
  assign op_off_o   = addr_q[1:0];
  assign clr_o      = accept;

  AST_ORDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && $past(cfg_q)) |-> $stable(le_q)); // R1
  AST_REJECT_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(bus_cyc_o)); // R9
  AST_SPLIT_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && $past(bus_cyc_o)) |->
      bus_addr_o == $past(bus_addr_o) + ADDR_W'(3'd1 << dw_q)); // R7
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_cyc_o)); // R10
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: rtl/bus_sizer_lane.sv
`timescale 1ns/1ps
module bus_sizer_lane
  import bus_sizer_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              le_i,
  input  logic [1:0]        dw_i,
  input  logic [1:0]        sz_i,
  input  logic [1:0]        op_off_i,
  input  logic [1:0]        win_off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              act_o,
  output logic [1:0]        idx_o,
  output logic [7:0]        wbyte_o
);
  localparam logic [2:0] LANE_V = 3'(LANE);

  logic [2:0] w_b, s_b, k, boff, lo, hi;
  logic       in_dev;

  assign w_b    = 3'd1 << dw_i;
  assign s_b    = 3'd1 << sz_i;
  assign in_dev = LANE_V < w_b;
  // byte offset inside the device word carried by this lane
  assign k      = le_i ? LANE_V : (w_b - 3'd1 - LANE_V);
  assign boff   = {1'b0, win_off_i} + k;
  assign lo     = {1'b0, op_off_i};
  assign hi     = lo + s_b;
  assign act_o  = in_dev && (boff >= lo) && (boff < hi);
  // operand byte number (0 = least significant)
  assign idx_o  = le_i ? 2'(boff - lo) : 2'(hi - 3'd1 - boff);
  assign wbyte_o = wdata_i[idx_o*8 +: 8];
endmodule

// File: rtl/bus_sizer_merge.sv
`timescale 1ns/1ps
module bus_sizer_merge
  import bus_sizer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic [LANES-1:0]      act_i,
  input  logic [LANES-1:0][1:0] idx_i,
  input  logic [DATA_W-1:0]     bus_rdata_i,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (clr_i) begin
      rd_q <= '0;
    end else if (cap_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (act_i[l]) rd_q[idx_i[l]*8 +: 8] <= bus_rdata_i[l*8 +: 8];
      end
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bus_sizer.sv
`timescale 1ns/1ps
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              endian_mode_i,
  input  logic [1:0]        dev_width_i,
  input  logic              req_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              bus_cyc_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [3:0]        bus_strb_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i
);
  logic                  le, we, clr;
  logic [1:0]            dw, sz, op_off, win_off;
  logic [DATA_W-1:0]     wd_q;
  logic [LANES-1:0]      act;
  logic [LANES-1:0][1:0] idx;
  logic [LANES-1:0][7:0] wbyte;
  logic [3:0]            dev_mask;
  logic [2:0]            n_strb;

  bus_sizer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .endian_mode_i, .dev_width_i, .req_i, .addr_i, .size_i,
    .we_i, .wdata_i, .ready_o, .done_o, .err_o, .bus_cyc_o, .bus_addr_o,
    .le_o(le), .we_o(we), .wdata_o(wd_q), .dw_o(dw), .sz_o(sz),
    .op_off_o(op_off), .win_off_o(win_off), .clr_o(clr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bus_sizer_lane #(.LANE(l)) u_lane (
      .le_i(le), .dw_i(dw), .sz_i(sz), .op_off_i(op_off), .win_off_i(win_off),
      .wdata_i(wd_q), .act_o(act[l]), .idx_o(idx[l]), .wbyte_o(wbyte[l])
    );
    assign bus_strb_o[l]        = bus_cyc_o && act[l];
    assign bus_wdata_o[l*8 +: 8] = (bus_cyc_o && we && act[l]) ? wbyte[l] : 8'h00;
  end

  bus_sizer_merge u_merge (
    .clk_i, .rst_ni, .clr_i(clr), .cap_i(bus_cyc_o && !we), .act_i(act),
    .idx_i(idx), .bus_rdata_i, .rdata_o
  );

  assign bus_we_o = bus_cyc_o && we;

  always_comb begin
    unique case (dw)
      SZ_BYTE: dev_mask = 4'h1;
      SZ_WORD: dev_mask = 4'h3;
      default: dev_mask = 4'hF;
    endcase
    n_strb = 3'd1 << ((sz < dw) ? sz : dw);
  end

  AST_STRB_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> ($countones(bus_strb_o) == 32'(n_strb))); // R11
  AST_STRB_IN_DEVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> ((bus_strb_o & ~dev_mask) == 4'h0)); // R6
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cyc_o |-> (bus_strb_o == 4'h0 && bus_wdata_o == 32'h0)); // R11
endmodule

// File: tb/tb_bus_sizer.sv
`timescale 1ns/1ps
module tb_bus_sizer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        endian_mode_i = 1'b0;
  logic [1:0]  dev_width_i = 2'd2;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, done_o, err_o, bus_cyc_o, bus_we_o;
  logic [31:0] rdata_o, bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic [3:0]  bus_strb_o;

  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  // device model: read data depends on the bus address
  assign bus_rdata_i = 32'hD3D2D1D0 ^ {4{bus_addr_o[7:0]}};

  bus_sizer dut (
    .clk_i(clk), .rst_ni, .endian_mode_i, .dev_width_i, .req_i, .ready_o,
    .addr_i, .size_i, .we_i, .wdata_i, .done_o, .err_o, .rdata_o, .bus_cyc_o,
    .bus_we_o, .bus_addr_o, .bus_strb_o, .bus_wdata_o, .bus_rdata_i
  );

  int          ncyc, lat;
  bit          g_done, g_err, ready_busy, extra;
  logic [31:0] g_rd;
  logic [31:0] c_addr [4];
  logic [3:0]  c_strb [4];
  logic [31:0] c_wd   [4];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset(input bit e);
    @(negedge clk);
    rst_ni = 1'b0; endian_mode_i = e; req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ready_o && !bus_cyc_o && !done_o && !err_o, "R1 reset quiet",
        {ready_o, bus_cyc_o, done_o, err_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o, "R1 ready after capture", ready_o, 1);
    endian_mode_i = ~e;  // must be ignored from here on
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit w, input logic [31:0] wd);
    ncyc = 0; lat = 0; g_done = 0; g_err = 0; ready_busy = 0; g_rd = '0;
    @(negedge clk);
    addr_i = a; size_i = sz; we_i = w; wdata_i = wd; req_i = 1'b1;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      lat++;
      if (bus_cyc_o) begin
        if (ncyc < 4) begin
          c_addr[ncyc] = bus_addr_o; c_strb[ncyc] = bus_strb_o; c_wd[ncyc] = bus_wdata_o;
        end
        if (ready_o) ready_busy = 1;
        ncyc++;
      end
      if (done_o || err_o) begin
        g_done = done_o; g_err = err_o; g_rd = rdata_o; req_i = 1'b0;
        break;
      end
    end
    req_i = 1'b0;
    @(negedge clk);
    extra = done_o || err_o;
  endtask

  task automatic chk_cycle(input string rq, input int i, input logic [31:0] ea,
                           input logic [3:0] es, input logic [31:0] ew);
    chk(c_addr[i] == ea, {rq, " addr"}, c_addr[i], ea);
    chk(c_strb[i] == es, {rq, " strobes"}, 32'(c_strb[i]), 32'(es));
    chk(c_wd[i] == ew, {rq, " lane data"}, c_wd[i], ew);
  endtask

  task automatic chk_single(input string rq, input logic [31:0] ea, input logic [3:0] es, input logic [31:0] ew);
    chk(g_done && ncyc == 1, {rq, " one cycle"}, ncyc, 1);
    chk_cycle(rq, 0, ea, es, ew);
  endtask

  task automatic t_be_byte_lanes;
    dev_width_i = 2'd2;
    for (int k = 0; k < 4; k++) begin
      access(32'h100 + k, 2'd0, 1, 32'hFFFF_FFA5);
      chk_single("R3 be byte", 32'h100, 4'b1000 >> k, 32'hA5 << (8 * (3 - k)));
    end
  endtask

  task automatic t_be_word_long;
    dev_width_i = 2'd2;
    access(32'h200, 2'd1, 1, 32'h0000_BEEF);
    chk_single("R4 be word off0", 32'h200, 4'hC, 32'hBEEF_0000);
    access(32'h202, 2'd1, 1, 32'h0000_BEEF);
    chk_single("R4 be word off2", 32'h200, 4'h3, 32'h0000_BEEF);
    access(32'h204, 2'd2, 1, 32'h1234_5678);
    chk_single("R4 be long", 32'h204, 4'hF, 32'h1234_5678);
  endtask

  task automatic t_be_reads;
    dev_width_i = 2'd2;
    access(32'h40, 2'd2, 0, 0);
    chk(g_done && g_rd == 32'h9392_9190, "R8 be long read", g_rd, 32'h9392_9190);
    access(32'h41, 2'd0, 0, 0);
    chk(g_rd == 32'h92, "R8 be byte read zero-extended", g_rd, 32'h92);
    chk(c_strb[0] == 4'b0100, "R3 be byte read strobe", 32'(c_strb[0]), 32'h4);
    access(32'h42, 2'd1, 0, 0);
    chk(g_rd == 32'h9190, "R8 be word read", g_rd, 32'h9190);
  endtask

  task automatic t_be_split;
    dev_width_i = 2'd0;
    access(32'h80, 2'd2, 0, 0);
    chk(ncyc == 4 && lat == 5, "R7 four byte cycles", ncyc, 4);
    for (int i = 0; i < 4; i++) chk_cycle("R7 byte dev read", i, 32'h80 + i, 4'h1, 32'h0);
    chk(g_rd == 32'h5051_5253, "R8 be merge byte dev", g_rd, 32'h5051_5253);
    access(32'h12, 2'd1, 1, 32'h0000_1234);
    chk(ncyc == 2, "R7 word on byte dev", ncyc, 2);
    chk_cycle("R6 be word on byte dev", 0, 32'h12, 4'h1, 32'h12);
    chk_cycle("R6 be word on byte dev", 1, 32'h13, 4'h1, 32'h34);
    dev_width_i = 2'd1;
    access(32'h20, 2'd2, 1, 32'hA1B2_C3D4);
    chk(ncyc == 2, "R7 long on word dev", ncyc, 2);
    chk_cycle("R6 be long on word dev", 0, 32'h20, 4'h3, 32'h0000_A1B2);
    chk_cycle("R6 be long on word dev", 1, 32'h22, 4'h3, 32'h0000_C3D4);
    access(32'h20, 2'd2, 0, 0);
    chk(g_rd == 32'hF1F0_F3F2, "R8 be merge word dev", g_rd, 32'hF1F0_F3F2);
  endtask

  task automatic t_reject;
    dev_width_i = 2'd2;
    access(32'h303, 2'd1, 1, 32'h1);
    chk(g_err && !g_done && ncyc == 0 && !extra, "R9 odd word", {g_err, g_done}, 32'h2);
    access(32'h302, 2'd2, 0, 0);
    chk(g_err && ncyc == 0 && lat == 1, "R9 misaligned long", ncyc, 0);
    access(32'h300, 2'd3, 0, 0);
    chk(g_err && ncyc == 0, "R9 reserved size", {g_err, g_done}, 32'h2);
    dev_width_i = 2'd3;
    access(32'h300, 2'd0, 0, 0);
    chk(g_err && ncyc == 0, "R9 reserved width", {g_err, g_done}, 32'h2);
    dev_width_i = 2'd2;
  endtask

  task automatic t_handshake;
    dev_width_i = 2'd0;
    access(32'h84, 2'd2, 1, 32'h0102_0304);
    chk(!ready_busy, "R10 ready low while busy", ready_busy, 0);
    chk(g_done && lat == ncyc + 1, "R10 done latency", lat, ncyc + 1);
    chk(!extra, "R10 done single pulse", extra, 0);
    chk(bus_strb_o == 0 && bus_wdata_o == 0 && !bus_cyc_o, "R11 quiet bus when idle",
        bus_wdata_o, 0);
    chk(c_wd[0] == 32'h01 && c_wd[3] == 32'h04, "R2 byte dev code", c_wd[3], 32'h04);
  endtask

  task automatic t_order_hold_be;
    dev_width_i = 2'd2;
    access(32'h100, 2'd0, 1, 32'h5A);  // endian_mode_i is high now
    chk_single("R1 order held after input change", 32'h100, 4'h8, 32'h5A00_0000);
  endtask

  task automatic t_le;
    dev_width_i = 2'd2;
    access(32'h100, 2'd0, 1, 32'hA5);
    chk_single("R5 le byte off0", 32'h100, 4'h1, 32'hA5);
    access(32'h103, 2'd0, 1, 32'hA5);
    chk_single("R5 le byte off3", 32'h100, 4'h8, 32'hA500_0000);
    access(32'h202, 2'd1, 1, 32'hBEEF);
    chk_single("R5 le word off2", 32'h200, 4'hC, 32'hBEEF_0000);
    access(32'h42, 2'd0, 0, 0);
    chk(g_rd == 32'h92, "R8 le byte read", g_rd, 32'h92);
    access(32'h42, 2'd1, 0, 0);
    chk(g_rd == 32'h9392, "R8 le word read", g_rd, 32'h9392);
    dev_width_i = 2'd0;
    access(32'h80, 2'd2, 0, 0);
    chk(g_rd == 32'h5352_5150, "R8 le merge byte dev", g_rd, 32'h5352_5150);
    dev_width_i = 2'd1;
    access(32'h20, 2'd2, 1, 32'hA1B2_C3D4);
    chk_cycle("R6 le long on word dev", 0, 32'h20, 4'h3, 32'h0000_C3D4);
    chk_cycle("R6 le long on word dev", 1, 32'h22, 4'h3, 32'h0000_A1B2);
    access(32'h20, 2'd2, 0, 0);
    chk(g_rd == 32'hF3F2_F1F0, "R8 le merge word dev", g_rd, 32'hF3F2_F1F0);
  endtask

  initial begin
    do_reset(1'b0);
    t_be_byte_lanes();
    t_be_word_long();
    t_be_reads();
    t_be_split();
    t_reject();
    t_handshake();
    t_order_hold_be();
    do_reset(1'b1);
    t_le();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule